// File: doc/BRIEF.md
# SDRAM Single-Beat Command Controller

This block sits between a request stream and a bank of SDRAM or SGRAM devices with a 64-bit data bus. Each request asks for one word: a read or a write, with a bank, a row, a column, write data and a tag. The block turns each request into the memory commands it needs. It keeps one open-row record for each of the two banks. A request to an open row goes straight out as a column command. A request to an idle bank first gets an Active. A request to a different row in an open bank first gets a Precharge of that bank and then an Active.

Every burst is one word long, so row hits can stream at one column command per clock. The bank is selected by the level of the second chip-select line. After reset the block issues a precharge of all banks and then one mode-register load with a fixed opcode. Only after that does it accept requests.

Read data is captured from the bus at a fixed latency. It is returned with a one-cycle valid pulse and the tag of the request. The data mask acts in the same cycle as a write command and two cycles after a read command.

Top module: `sdram_beat_ctrl`

## Requirements
- R1: While reset is held, the block behaves as follows:
  - chip select 0 is high (command inhibit);
  - `req_ready` and `rd_valid` are low;
  - the data bus is not driven;
  - `mem_dqm` is high;
  - `mem_cke` is high and `mem_dsf` is low, as they are at all times.
- R2: After reset is released, the next clock drives a precharge of all banks, with address bit 10 high. Exactly two cycles later the block drives a mode-register load. Its opcode is parameter `MODE_OP`: bit 11 goes on `mem_cs1_n` and bits 10:0 go on `mem_addr`.
- R3: The command pins {cs0_n, ras_n, cas_n, we_n} use these codes:
  - NOP 0111
  - Active 0011
  - Read 0101
  - Write 0100
  - Precharge 0010
  - Load mode 0000
  - Inhibit is cs0_n high.
- R4: A request to a bank with no open row drives Active, with the row on `mem_addr` and the bank on `mem_cs1_n`. The column command follows exactly two cycles later.
- R5: A request that misses the open row of its bank drives a single-bank Precharge (address bit 10 low, bank on `mem_cs1_n`). Two cycles later it drives Active, and two cycles after that the column command.
- R6: A request that hits an open row is accepted at once, and its column command is on the pins in the next cycle. Back-to-back hits issue one column command per cycle, with no Active or Precharge in between.
- R7: On a Read or Write command:
  - `mem_addr[7:0]` carries the column;
  - `mem_addr[10:8]` are zero, so address bit 10 is low and no auto-precharge is used;
  - `mem_cs1_n` carries the bank.
- R8: `req_ready` is high only in a cycle where the pending request can be issued as a column command. It stays low during the Precharge-to-Active and Active-to-column gaps.
- R9: In the cycle of a Write command, `mem_dqm` is low, `mem_dq_oe` is high and `mem_dq_out` equals the request's write data. `mem_dq_oe` is low in every other cycle.
- R10: `mem_dqm` goes low in the second cycle after a Read command, and is high in the first cycle after it when no write is in flight.
- R11: `rd_valid` pulses for one cycle, three cycles after a Read command is on the pins. `rd_data` holds the bus value present two cycles after the Read, and `rd_tag` holds the request's tag.
- R12: The open rows of the two banks are independent: opening a row in one bank leaves the other bank's open row a hit.
- R13: With no request pending and no gap running, the block drives NOP (chip select 0 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change and are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank of the request |
| req_row | input | 11 | Row of the request |
| req_col | input | 8 | Column of the request |
| req_wdata | input | 64 | Write data |
| req_tag | input | 4 | Tag returned with read data |
| mem_cke | output | 1 | Clock enable, held high |
| mem_dsf | output | 1 | Special-function select, held low |
| mem_cs0_n | output | 1 | Chip select 0, active low |
| mem_cs1_n | output | 1 | Bank select / opcode bit 11 |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dqm | output | 1 | Data mask / output enable, active low |
| mem_addr | output | 11 | Row, column or opcode |
| mem_dq_out | output | 64 | Write data to the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 64 | Read data from the bus |
| rd_valid | output | 1 | Read word valid pulse |
| rd_tag | output | 4 | Tag of the returned word |
| rd_data | output | 64 | Returned read word |

## Verification
The properties check every cycle that the command codes are legal and that column commands keep address bit 10 low. They also check that no Active directly follows a Precharge and no column command directly follows an Active. They check that an accepted request appears as a column command on its bank in the next cycle, that the bus is driven only with a write and an open mask, and that each returned word follows a read-phase mask cycle.

Only the directed scenarios show the exact cycle spacing of the start-up and miss sequences, and that the right row and column reach the pins. They also show which tag and which bus word come back, that hits stream one per cycle, and that the open row of one bank survives work on the other.

// File: rtl/sdram_beat_pkg.sv
package sdram_beat_pkg;

  localparam int BANK_W = 1;
  localparam int NBANK  = 1 << BANK_W;

  typedef enum logic [2:0] {
    CMD_INH, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_LMR
  } cmd_e;

  // {cs0_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      CMD_NOP: return 4'b0111;
      CMD_ACT: return 4'b0011;
      CMD_RD:  return 4'b0101;
      CMD_WR:  return 4'b0100;
      CMD_PRE: return 4'b0010;
      CMD_LMR: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdr_row_track.sv
module sdr_row_track
  import sdram_beat_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_hit,
  output logic              look_idle,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              pre_en,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] pre_bank
);

  logic [NBANK-1:0] bank_open;
  logic [ROW_W-1:0] bank_row [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    wire close_me = pre_en && (pre_all || (pre_bank == BANK_W'(b)));
    wire open_me  = act_en && (act_bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (close_me) begin
        open_q <= 1'b0;
      end else if (open_me) begin
        open_q <= 1'b1;
        row_q  <= act_row;
      end
    end

    assign bank_open[b] = open_q;
    assign bank_row[b]  = row_q;
  end

  assign look_idle = !bank_open[look_bank];
  assign look_hit  = bank_open[look_bank] && (bank_row[look_bank] == look_row);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
  import sdram_beat_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_MRD = 2,
  parameter logic [ROW_W+BANK_W-1:0] MODE_OP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              look_hit,
  input  logic              look_idle,
  output cmd_e              nxt_cmd,
  output logic [BANK_W-1:0] nxt_bank,
  output logic [ROW_W-1:0]  nxt_addr,
  output logic              req_ready,
  output logic              act_en,
  output logic              pre_en,
  output logic              pre_all,
  output logic              gap_zero
);

  localparam int AP_BIT = 10;
  localparam int T_MAX  = max3(T_RP, T_RCD, T_MRD);
  localparam int GW     = $clog2(T_MAX + 1);

  typedef enum logic [1:0] {ST_PALL, ST_LMR, ST_RUN} st_e;

  st_e           st_q, st_d;
  logic [GW-1:0] gap_q, gap_d;

  // Gap counter value so that the next command lands t cycles later.
  function automatic logic [GW-1:0] gap_of(int unsigned t);
    return (t > 1) ? GW'(t - 1) : '0;
  endfunction

  assign gap_zero = (gap_q == '0);

  always_comb begin
    st_d      = st_q;
    gap_d     = gap_zero ? '0 : gap_q - 1'b1;
    nxt_cmd   = CMD_NOP;
    nxt_bank  = '0;
    nxt_addr  = '0;
    req_ready = 1'b0;
    act_en    = 1'b0;
    pre_en    = 1'b0;
    pre_all   = 1'b0;
    if (gap_zero) begin
      case (st_q)
        ST_PALL: begin
          nxt_cmd          = CMD_PRE;
          nxt_addr[AP_BIT] = 1'b1;
          pre_en           = 1'b1;
          pre_all          = 1'b1;
          gap_d            = gap_of(T_RP);
          st_d             = ST_LMR;
        end
        ST_LMR: begin
          nxt_cmd  = CMD_LMR;
          nxt_bank = MODE_OP[ROW_W +: BANK_W];
          nxt_addr = MODE_OP[ROW_W-1:0];
          gap_d    = gap_of(T_MRD);
          st_d     = ST_RUN;
        end
        default: begin
          if (req_valid) begin
            nxt_bank = req_bank;
            if (look_hit) begin
              req_ready = 1'b1;
              nxt_cmd   = req_write ? CMD_WR : CMD_RD;
              nxt_addr  = {{(ROW_W-COL_W){1'b0}}, req_col};
            end else if (look_idle) begin
              nxt_cmd  = CMD_ACT;
              nxt_addr = req_row;
              act_en   = 1'b1;
              gap_d    = gap_of(T_RCD);
            end else begin
              nxt_cmd = CMD_PRE;
              pre_en  = 1'b1;
              gap_d   = gap_of(T_RP);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PALL;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
    end
  end

endmodule

// File: rtl/sdr_rd_return.sv
module sdr_rd_return #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rd_mask_open,
  output logic              rd_phase,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  logic [RD_LAT-1:0] rd_sr;
  logic [TAG_W-1:0]  tag_sr [RD_LAT];
  logic [TAG_W-1:0]  phase_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sr <= '0;
      for (int i = 0; i < RD_LAT; i++) tag_sr[i] <= '0;
      rd_phase  <= 1'b0;
      phase_tag <= '0;
      rd_valid  <= 1'b0;
      rd_tag    <= '0;
      rd_data   <= '0;
    end else begin
      rd_sr[0]  <= rd_issue;
      tag_sr[0] <= issue_tag;
      for (int i = 1; i < RD_LAT; i++) begin
        rd_sr[i]  <= rd_sr[i-1];
        tag_sr[i] <= tag_sr[i-1];
      end
      rd_phase  <= rd_sr[RD_LAT-1];
      phase_tag <= tag_sr[RD_LAT-1];
      rd_valid  <= rd_phase;
      if (rd_phase) begin
        rd_tag  <= phase_tag;
        rd_data <= mem_dq_in;
      end
    end
  end

  // Mask must open on the pins RD_LAT cycles after the Read
  assign rd_mask_open = rd_sr[RD_LAT-1];

endmodule

// File: rtl/sdram_beat_ctrl.sv
module sdram_beat_ctrl
  import sdram_beat_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_MRD  = 2,
  parameter int RD_LAT = 2,
  parameter logic [ROW_W+BANK_W-1:0] MODE_OP = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              mem_cke,
  output logic              mem_dsf,
  output logic              mem_cs0_n,
  output logic              mem_cs1_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_dqm,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);

  cmd_e              nxt_cmd;
  logic [BANK_W-1:0] nxt_bank;
  logic [ROW_W-1:0]  nxt_addr;
  logic              look_hit, look_idle;
  logic              act_en, pre_en, pre_all;
  logic              seq_gap_zero;
  logic              rd_mask_open, rd_phase;

  // Named events for the checker
  wire wr_issue = (nxt_cmd == CMD_WR);
  wire rd_issue = (nxt_cmd == CMD_RD);

  sdr_row_track #(.ROW_W(ROW_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_hit  (look_hit),
    .look_idle (look_idle),
    .act_en    (act_en),
    .act_bank  (nxt_bank),
    .act_row   (req_row),
    .pre_en    (pre_en),
    .pre_all   (pre_all),
    .pre_bank  (nxt_bank)
  );

  sdr_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_MRD(T_MRD), .MODE_OP(MODE_OP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .look_hit  (look_hit),
    .look_idle (look_idle),
    .nxt_cmd   (nxt_cmd),
    .nxt_bank  (nxt_bank),
    .nxt_addr  (nxt_addr),
    .req_ready (req_ready),
    .act_en    (act_en),
    .pre_en    (pre_en),
    .pre_all   (pre_all),
    .gap_zero  (seq_gap_zero)
  );

  sdr_rd_return #(.DATA_W(DATA_W), .TAG_W(TAG_W), .RD_LAT(RD_LAT)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_issue     (rd_issue),
    .issue_tag    (req_tag),
    .mem_dq_in    (mem_dq_in),
    .rd_mask_open (rd_mask_open),
    .rd_phase     (rd_phase),
    .rd_valid     (rd_valid),
    .rd_tag       (rd_tag),
    .rd_data      (rd_data)
  );

  assign mem_cke = 1'b1;
  assign mem_dsf = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mem_cs0_n, mem_ras_n, mem_cas_n, mem_we_n} <= 4'b1111;
      mem_cs1_n  <= 1'b1;
      mem_addr   <= '0;
      mem_dqm    <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_dq_out <= '0;
    end else begin
      {mem_cs0_n, mem_ras_n, mem_cas_n, mem_we_n} <= cmd_pins(nxt_cmd);
      mem_cs1_n  <= nxt_bank[0];
      mem_addr   <= nxt_addr;
      mem_dqm    <= !(wr_issue || rd_mask_open);
      mem_dq_oe  <= wr_issue;
      mem_dq_out <= wr_issue ? req_wdata : '0;
    end
  end

endmodule

// File: rtl/sdram_beat_chk.sv
module sdram_beat_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_bank,
  input logic             mem_cs0_n,
  input logic             mem_cs1_n,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic             mem_dqm,
  input logic             mem_dq_oe,
  input logic [ROW_W-1:0] mem_addr,
  input logic             rd_valid,
  input logic             seq_gap_zero
);

  wire [3:0] pins    = {mem_cs0_n, mem_ras_n, mem_cas_n, mem_we_n};
  wire       is_act  = (pins == 4'b0011);
  wire       is_pre  = (pins == 4'b0010);
  wire       is_wr   = (pins == 4'b0100);
  wire       is_col  = (pins == 4'b0101) || is_wr;
  wire       legal   = (pins == 4'b0111) || is_act || is_col || is_pre || (pins == 4'b0000);

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs0_n |-> legal);

  // R7
  col_no_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !mem_addr[10]);

  // R5
  pre_act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !$past(is_pre));

  // R4
  act_col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !$past(is_act));

  // R6
  accept_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (is_col && (mem_cs1_n == $past(req_bank))));

  // R8
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> seq_gap_zero);

  // R9
  drive_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (is_wr && !mem_dqm));

  // R11
  return_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_dqm && !mem_dq_oe));

endmodule

bind sdram_beat_ctrl sdram_beat_chk #(.ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_bank     (req_bank),
  .mem_cs0_n    (mem_cs0_n),
  .mem_cs1_n    (mem_cs1_n),
  .mem_ras_n    (mem_ras_n),
  .mem_cas_n    (mem_cas_n),
  .mem_we_n     (mem_we_n),
  .mem_dqm      (mem_dqm),
  .mem_dq_oe    (mem_dq_oe),
  .mem_addr     (mem_addr),
  .rd_valid     (rd_valid),
  .seq_gap_zero (seq_gap_zero)
);

// File: tb/sdram_beat_ctrl_test.sv
module sdram_beat_ctrl_test;

  localparam logic [11:0] MODE = 12'h020;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_LMR = 4'b0000;
  localparam int LOGN = 4096;
  localparam int WDOG = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [63:0] req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic [63:0] mem_dq_in = '0;
  logic req_ready, mem_cke, mem_dsf, mem_cs0_n, mem_cs1_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic mem_dqm, mem_dq_oe, rd_valid;
  logic [10:0] mem_addr;
  logic [63:0] mem_dq_out, rd_data;
  logic [3:0]  rd_tag;

  always #5 clk = ~clk;

  sdram_beat_ctrl #(.MODE_OP(MODE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_tag(req_tag), .mem_cke(mem_cke), .mem_dsf(mem_dsf),
    .mem_cs0_n(mem_cs0_n), .mem_cs1_n(mem_cs1_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dqm(mem_dqm), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [3:0]  lg_cmd   [LOGN];
  logic        lg_cs1   [LOGN];
  logic [10:0] lg_addr  [LOGN];
  logic        lg_dqm   [LOGN];
  logic        lg_oe    [LOGN];
  logic [63:0] lg_dq    [LOGN];
  logic        lg_rv    [LOGN];
  logic [63:0] lg_rdata [LOGN];
  logic [3:0]  lg_rtag  [LOGN];

  function automatic logic [63:0] pat(logic b, logic [7:0] c);
    return {8'hA5, 47'd0, b, c};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Pin log and a bus model that answers each Read two cycles later
  always @(negedge clk) begin
    if (cyc < LOGN) begin
      lg_cmd[cyc]   = {mem_cs0_n, mem_ras_n, mem_cas_n, mem_we_n};
      lg_cs1[cyc]   = mem_cs1_n;
      lg_addr[cyc]  = mem_addr;
      lg_dqm[cyc]   = mem_dqm;
      lg_oe[cyc]    = mem_dq_oe;
      lg_dq[cyc]    = mem_dq_out;
      lg_rv[cyc]    = rd_valid;
      lg_rdata[cyc] = rd_data;
      lg_rtag[cyc]  = rd_tag;
      if (cyc >= 2 && lg_cmd[cyc-2] == C_RD)
        mem_dq_in = pat(lg_cs1[cyc-2], lg_addr[cyc-2][7:0]);
      else
        mem_dq_in = 64'hDEAD_BEEF_DEAD_BEEF;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one request; returns cycles with ready low and the pin cycle of its column command
  task automatic send(input logic w, input logic b, input logic [10:0] row, input logic [7:0] col,
                      input logic [63:0] d, input logic [3:0] tag, output int waits, output int pin);
    req_valid = 1'b1; req_write = w; req_bank = b; req_row = row;
    req_col = col; req_wdata = d; req_tag = tag;
    waits = 0;
    #1;
    while (!req_ready && waits < 50) begin
      waits++;
      @(negedge clk);
      #1;
    end
    pin = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    idle(3);
    chk(mem_cs0_n == 1'b1, "R1 inhibit", 64'(mem_cs0_n), 64'd1);
    chk(req_ready == 1'b0, "R1 ready", 64'(req_ready), 64'd0);
    chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
    chk(mem_dq_oe == 1'b0 && mem_dqm == 1'b1, "R1 bus", {62'd0, mem_dq_oe, mem_dqm}, 64'd1);
    chk(mem_cke == 1'b1 && mem_dsf == 1'b0, "R1 cke/dsf", {62'd0, mem_cke, mem_dsf}, 64'd2);
  endtask

  task automatic t_init;
    int rel;
    rel = cyc;
    rst_n = 1'b1;
    idle(8);
    chk(lg_cmd[rel+1] == C_PRE && lg_addr[rel+1][10], "R2 precharge all",
        {lg_addr[rel+1], lg_cmd[rel+1]}, {11'h400, C_PRE});
    chk(lg_cmd[rel+2] == C_NOP, "R2 gap", 64'(lg_cmd[rel+2]), 64'(C_NOP));
    chk(lg_cmd[rel+3] == C_LMR, "R2 load mode", 64'(lg_cmd[rel+3]), 64'(C_LMR));
    chk({lg_cs1[rel+3], lg_addr[rel+3]} == MODE, "R2 opcode",
        64'({lg_cs1[rel+3], lg_addr[rel+3]}), 64'(MODE));
    chk(lg_cmd[rel+6] == C_NOP, "R13 idle nop", 64'(lg_cmd[rel+6]), 64'(C_NOP));
  endtask

  task automatic t_idle_read;
    int w, p;
    send(1'b0, 1'b0, 11'h155, 8'h21, '0, 4'd3, w, p);
    idle(6);
    chk(w == 2, "R8 ready low in act gap", 64'(w), 64'd2);
    chk(lg_cmd[p-2] == C_ACT && lg_addr[p-2] == 11'h155 && lg_cs1[p-2] == 1'b0, "R4 active",
        {lg_cs1[p-2], lg_addr[p-2], lg_cmd[p-2]}, {1'b0, 11'h155, C_ACT});
    chk(lg_cmd[p-1] == C_NOP, "R4 gap", 64'(lg_cmd[p-1]), 64'(C_NOP));
    chk(lg_cmd[p] == C_RD && lg_addr[p] == 11'h021 && lg_cs1[p] == 1'b0, "R7 read fields",
        {lg_cs1[p], lg_addr[p], lg_cmd[p]}, {1'b0, 11'h021, C_RD});
    chk(lg_dqm[p+1] == 1'b1 && lg_dqm[p+2] == 1'b0 && lg_dqm[p+3] == 1'b1, "R10 read mask",
        {lg_dqm[p+1], lg_dqm[p+2], lg_dqm[p+3]}, 64'b101);
    chk(!lg_rv[p+2] && lg_rv[p+3] && !lg_rv[p+4], "R11 valid pulse",
        {lg_rv[p+2], lg_rv[p+3], lg_rv[p+4]}, 64'b010);
    chk(lg_rdata[p+3] == pat(1'b0, 8'h21), "R11 data", lg_rdata[p+3], pat(1'b0, 8'h21));
    chk(lg_rtag[p+3] == 4'd3, "R11 tag", 64'(lg_rtag[p+3]), 64'd3);
  endtask

  task automatic t_hit_stream;
    int w0, w1, w2, w3, p0, p1, p2, p3;
    send(1'b1, 1'b0, 11'h155, 8'h01, 64'h1111_2222_3333_4444, 4'd1, w0, p0);
    send(1'b0, 1'b0, 11'h155, 8'h01, '0, 4'd2, w1, p1);
    send(1'b1, 1'b0, 11'h155, 8'h02, 64'h5555_6666_7777_8888, 4'd7, w2, p2);
    send(1'b0, 1'b0, 11'h155, 8'h03, '0, 4'd4, w3, p3);
    idle(7);
    chk(w0 + w1 + w2 + w3 == 0, "R6 no stall on hits", 64'(w0 + w1 + w2 + w3), 64'd0);
    chk(p1 == p0 + 1 && p2 == p0 + 2 && p3 == p0 + 3, "R6 one per cycle", 64'(p3 - p0), 64'd3);
    chk(lg_cmd[p0] == C_WR && lg_cmd[p1] == C_RD && lg_cmd[p2] == C_WR && lg_cmd[p3] == C_RD,
        "R6 column order", {lg_cmd[p0], lg_cmd[p1], lg_cmd[p2], lg_cmd[p3]},
        {C_WR, C_RD, C_WR, C_RD});
    chk(!lg_dqm[p0] && lg_oe[p0] && lg_dq[p0] == 64'h1111_2222_3333_4444, "R9 write data",
        lg_dq[p0], 64'h1111_2222_3333_4444);
    chk(lg_oe[p2] && lg_dq[p2] == 64'h5555_6666_7777_8888 && !lg_oe[p1] && !lg_oe[p3],
        "R9 drive only on write", {lg_oe[p0], lg_oe[p1], lg_oe[p2], lg_oe[p3]}, 64'b1010);
    chk(lg_rv[p1+3] && lg_rdata[p1+3] == pat(1'b0, 8'h01) && lg_rtag[p1+3] == 4'd2,
        "R11 stream read 1", lg_rdata[p1+3], pat(1'b0, 8'h01));
    chk(lg_rv[p3+3] && lg_rdata[p3+3] == pat(1'b0, 8'h03) && lg_rtag[p3+3] == 4'd4,
        "R11 stream read 2", {lg_rtag[p3+3], lg_rdata[p3+3][59:0]}, {4'd4, pat(1'b0, 8'h03)});
  endtask

  task automatic t_row_miss;
    int w, p;
    send(1'b0, 1'b0, 11'h2AA, 8'h07, '0, 4'd5, w, p);
    idle(6);
    chk(w == 4, "R8 ready low in miss gaps", 64'(w), 64'd4);
    chk(lg_cmd[p-4] == C_PRE && !lg_addr[p-4][10] && lg_cs1[p-4] == 1'b0, "R5 bank precharge",
        {lg_cs1[p-4], lg_addr[p-4][10], lg_cmd[p-4]}, {2'b00, C_PRE});
    chk(lg_cmd[p-3] == C_NOP && lg_cmd[p-1] == C_NOP, "R5 gaps",
        {lg_cmd[p-3], lg_cmd[p-1]}, {C_NOP, C_NOP});
    chk(lg_cmd[p-2] == C_ACT && lg_addr[p-2] == 11'h2AA, "R5 active row",
        {lg_addr[p-2], lg_cmd[p-2]}, {11'h2AA, C_ACT});
    chk(lg_cmd[p] == C_RD && lg_rv[p+3] && lg_rtag[p+3] == 4'd5, "R5 read after miss",
        {lg_rtag[p+3], lg_cmd[p]}, {4'd5, C_RD});
  endtask

  task automatic t_other_bank;
    int w, p, wb, pb, wc, pc;
    send(1'b1, 1'b1, 11'h0F0, 8'h09, 64'hCAFE_F00D_0000_0009, 4'd0, w, p);
    send(1'b0, 1'b0, 11'h2AA, 8'h08, '0, 4'd6, wb, pb);
    send(1'b1, 1'b1, 11'h0F0, 8'h0A, 64'hCAFE_F00D_0000_000A, 4'd0, wc, pc);
    idle(6);
    chk(w == 2 && lg_cmd[p-2] == C_ACT && lg_cs1[p-2] == 1'b1 && lg_addr[p-2] == 11'h0F0,
        "R4 bank 1 active", {lg_cs1[p-2], lg_addr[p-2], lg_cmd[p-2]}, {1'b1, 11'h0F0, C_ACT});
    chk(lg_cmd[p] == C_WR && lg_cs1[p] == 1'b1 && lg_addr[p] == 11'h009, "R7 write fields",
        {lg_cs1[p], lg_addr[p], lg_cmd[p]}, {1'b1, 11'h009, C_WR});
    chk(wb == 0 && lg_cmd[pb] == C_RD && lg_cs1[pb] == 1'b0, "R12 bank 0 still open",
        64'(wb), 64'd0);
    chk(wc == 0 && lg_cmd[pc] == C_WR && lg_cs1[pc] == 1'b1, "R12 bank 1 still open",
        64'(wc), 64'd0);
    chk(lg_cmd[pc+3] == C_NOP, "R13 nop when idle", 64'(lg_cmd[pc+3]), 64'(C_NOP));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_init();
    t_idle_read();
    t_hit_stream();
    t_row_miss();
    t_other_bank();
    finish_run();
  end

endmodule